// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address. It walks a two-level page table held in memory, one translation at a time. A requester presents an address and a write/read flag. The walker then reads a first-level entry through a simple request/response memory read port, and after that a second-level entry. It returns exactly one result for each request: either the physical address of a 4 KB page plus the page offset, or a fault. A fault carries its kind, the faulting virtual address and the direction of the access.

The first-level table is found through a directory base input, which is captured when a request is accepted. Each table holds 1024 entries of 4 bytes. An entry is valid when bit 0 is set. In a second-level entry, bit 1 allows reads and bit 2 allows writes, and bits 3 to 8 carry hints that the walker ignores. Only 4 KB pages exist, so no larger mapping is recognised.

The control is a single state machine. From ST_IDLE, an accepted request goes to ST_L1_ISSUE. Once the read port takes the fetch, the machine moves to ST_L1_WAIT. A valid first-level response leads to ST_L2_ISSUE and then ST_L2_WAIT. An error or invalid response at the first level goes straight to ST_REPORT. The second-level response always leads to ST_REPORT. ST_REPORT presents the result for one cycle and returns to ST_IDLE.

Top module: `ptw_walker`

## Requirements
- R1: Out of reset, req_ready is 1, res_valid is 0 and mem_req_valid is 0.
- R2: A request is accepted only while req_ready is 1, and req_ready stays 0 from the accepting edge until the walk has reported.
- R3: The first fetch address is dir_base + vaddr[31:22]*4. dir_base is sampled on the accepting edge, so later changes do not affect the walk in flight.
- R4: The second fetch address is the first-level entry with bit 0 cleared, plus vaddr[21:12]*4.
- R5: A permitted access reports res_fault_kind 0 and res_paddr = {second-level entry[31:12], vaddr[11:0]}.
- R6: A first-level entry with bit 0 clear ends the walk with res_fault_kind 1 (page fault), and no second fetch is issued.
- R7: A second-level entry with bit 0 clear ends the walk with res_fault_kind 1.
- R8: A read to a valid page without bit 1, or a write to one without bit 2, ends with res_fault_kind 1. Bits 3 to 8 have no effect on the outcome.
- R9: A response with mem_rsp_err set, at either level, ends the walk with res_fault_kind 2 (bus error). No further fetch follows.
- R10: Every accepted request gives exactly one res_valid pulse, one cycle long. On a fault, res_fault_addr equals the request address and res_fault_write equals its write flag.
- R11: While mem_req_valid is 1 and mem_req_ready is 0, the request and its address are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_is_write | input | 1 | 1 for a write access, 0 for a read |
| dir_base | input | 32 | Byte address of the first-level table |
| mem_req_valid | output | 1 | Entry fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 32 | Byte address of the entry to fetch |
| mem_rsp_valid | input | 1 | Fetch response present |
| mem_rsp_data | input | 32 | Fetched entry |
| mem_rsp_err | input | 1 | Response carries a bus error |
| res_valid | output | 1 | Result pulse |
| res_paddr | output | 32 | Physical address (0 on a fault) |
| res_fault_kind | output | 2 | 0 none, 1 page fault, 2 bus error |
| res_fault_addr | output | 32 | Faulting virtual address (0 without a fault) |
| res_fault_write | output | 1 | Write flag of the faulting access |

## Verification
The assertions take for granted that memory sends exactly one response per accepted fetch, and only while the walker waits for one. They also assume req_valid is presented only while req_ready is high. The bench memory model meets both conditions: it answers each handshake it sees once, after a varying delay, and keeps mem_rsp_valid low otherwise. The driver task waits for req_ready before it raises req_valid. To show that the captured base is the one in use, the stimulus changes dir_base while a walk is in flight. It also holds mem_req_ready low for some cycles to exercise the hold rule.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ENT_PRESENT_BIT = 0;
    localparam int ENT_READ_BIT    = 1;
    localparam int ENT_WRITE_BIT   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ISSUE,
        ST_L1_WAIT,
        ST_L2_ISSUE,
        ST_L2_WAIT,
        ST_REPORT
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_BUS  = 2'd2
    } fault_kind_t;
endpackage

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
(
    input  logic [2:0] entry_lo,
    input  logic       is_write,
    output logic       present,
    output logic       access_ok
);
    always_comb begin
        present   = entry_lo[ENT_PRESENT_BIT];
        access_ok = present &&
                    (is_write ? entry_lo[ENT_WRITE_BIT] : entry_lo[ENT_READ_BIT]);
    end
endmodule

// File: rtl/ptw_fetch_addr.sv
module ptw_fetch_addr #(
    parameter int VA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic            second_level,
    input  logic [VA_W-1:0] dir_base,
    input  logic [VA_W-1:1] l1_entry_hi,
    input  logic [VA_W-1:0] vaddr,
    output logic [VA_W-1:0] fetch_addr
);
    localparam int L2_LO = OFF_W;
    localparam int L1_LO = OFF_W + IDX_W;

    logic [IDX_W-1:0] idx1;
    logic [IDX_W-1:0] idx2;
    logic [VA_W-1:0]  table_base;
    logic [VA_W-1:0]  offset_bytes;

    always_comb begin
        idx1         = vaddr[L1_LO +: IDX_W];
        idx2         = vaddr[L2_LO +: IDX_W];
        table_base   = second_level ? {l1_entry_hi, 1'b0} : dir_base;
        offset_bytes = second_level ? VA_W'({idx2, 2'b00}) : VA_W'({idx1, 2'b00});
        fetch_addr   = table_base + offset_bytes;
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        l1_continue,
    output walk_state_t state,
    output logic        req_ready,
    output logic        mem_req_valid,
    output logic        second_level,
    output logic        res_valid,
    output logic        cap_req,
    output logic        cap_l1,
    output logic        finish
);
    walk_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (req_valid)     state_nx = ST_L1_ISSUE;
            ST_L1_ISSUE: if (mem_req_ready) state_nx = ST_L1_WAIT;
            ST_L1_WAIT:  if (mem_rsp_valid) state_nx = l1_continue ? ST_L2_ISSUE : ST_REPORT;
            ST_L2_ISSUE: if (mem_req_ready) state_nx = ST_L2_WAIT;
            ST_L2_WAIT:  if (mem_rsp_valid) state_nx = ST_REPORT;
            ST_REPORT:                      state_nx = ST_IDLE;
            default:                        state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_L1_ISSUE) || (state == ST_L2_ISSUE);
        second_level  = (state == ST_L2_ISSUE) || (state == ST_L2_WAIT);
        res_valid     = (state == ST_REPORT);
        cap_req       = (state == ST_IDLE) && req_valid;
        cap_l1        = (state == ST_L1_WAIT) && mem_rsp_valid;
        finish        = ((state == ST_L1_WAIT) || (state == ST_L2_WAIT)) &&
                        mem_rsp_valid && (state_nx == ST_REPORT);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_is_write,
    input  logic [VA_W-1:0] dir_base,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            res_valid,
    output logic [VA_W-1:0] res_paddr,
    output logic [1:0]      res_fault_kind,
    output logic [VA_W-1:0] res_fault_addr,
    output logic            res_fault_write
);
    localparam int FRAME_W = VA_W - OFF_W;

    walk_state_t     state;
    logic            second_level;
    logic            cap_req;
    logic            cap_l1;
    logic            finish;
    logic            ent_present;
    logic            ent_access_ok;
    logic            l1_continue;
    logic [VA_W-1:0] vaddr_q;
    logic [VA_W-1:0] base_q;
    logic [VA_W-1:0] l1_q;
    logic            wr_q;
    fault_kind_t     kind_q;
    logic [VA_W-1:0] paddr_q;
    fault_kind_t     kind_nx;

    ptw_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .l1_continue   (l1_continue),
        .state         (state),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .second_level  (second_level),
        .res_valid     (res_valid),
        .cap_req       (cap_req),
        .cap_l1        (cap_l1),
        .finish        (finish)
    );

    ptw_fetch_addr #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
        .second_level (second_level),
        .dir_base     (base_q),
        .l1_entry_hi  (l1_q[VA_W-1:1]),
        .vaddr        (vaddr_q),
        .fetch_addr   (mem_req_addr)
    );

    ptw_entry_eval u_eval (
        .entry_lo  (mem_rsp_data[2:0]),
        .is_write  (wr_q),
        .present   (ent_present),
        .access_ok (ent_access_ok)
    );

    always_comb begin
        l1_continue = !mem_rsp_err && ent_present;
        if (mem_rsp_err)
            kind_nx = FLT_BUS;
        else if (second_level ? !ent_access_ok : !ent_present)
            kind_nx = FLT_PAGE;
        else
            kind_nx = FLT_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            base_q  <= '0;
            l1_q    <= '0;
            wr_q    <= 1'b0;
            kind_q  <= FLT_NONE;
            paddr_q <= '0;
        end else begin
            if (cap_req) begin
                vaddr_q <= req_vaddr;
                base_q  <= dir_base;
                wr_q    <= req_is_write;
            end
            if (cap_l1)
                l1_q <= mem_rsp_data;
            if (finish) begin
                kind_q  <= kind_nx;
                paddr_q <= (kind_nx == FLT_NONE) ?
                           {mem_rsp_data[VA_W-1 -: FRAME_W], vaddr_q[OFF_W-1:0]} : '0;
            end
        end
    end

    always_comb begin
        res_paddr       = paddr_q;
        res_fault_kind  = kind_q;
        res_fault_addr  = (kind_q != FLT_NONE) ? vaddr_q : '0;
        res_fault_write = (kind_q != FLT_NONE) && wr_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [VA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            mem_rsp_err,
    input logic            res_valid,
    input logic [1:0]      res_fault_kind
);
    logic busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     busy <= 1'b0;
        else if (req_valid && req_ready) busy <= 1'b1;
        else if (res_valid)             busy <= 1'b0;
    end

    AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2

    AST_FETCH_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R2

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R10

    AST_RESULT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy); // R10

    AST_RESULT_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(mem_rsp_valid)); // R10

    AST_BUS_FROM_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault_kind == 2'd2) |-> $past(mem_rsp_err)); // R9
endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W)) chk_i (.*);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_is_write = 1'b0;
    logic [31:0] dir_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic [1:0]  res_fault_kind;
    logic [31:0] res_fault_addr;
    logic        res_fault_write;

    always #10 clk = ~clk;

    ptw_walker dut_i (.*);

    typedef struct {
        logic [31:0] paddr;
        logic [1:0]  kind;
        logic [31:0] faddr;
        logic        fwrite;
        string       tag;
    } exp_t;

    logic [31:0] mem [int unsigned];
    bit          errmap [int unsigned];
    exp_t        exp_q [$];
    logic [31:0] fetch_q [$];
    string       fetch_tag_q [$];
    int total = 0;
    int bad = 0;
    int n_req = 0;
    int n_res = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic translate(logic [31:0] va, logic w, logic [31:0] base, string tag);
        exp_t e;
        logic [31:0] a1, a2, e1, e2;
        bit perm;
        e.paddr = '0; e.faddr = va; e.fwrite = w; e.tag = tag;
        a1 = base + {20'd0, va[31:22], 2'b00};
        fetch_q.push_back(a1); fetch_tag_q.push_back({tag, " R3"});
        e1 = rd(a1);
        if (errmap.exists(a1)) e.kind = 2'd2;
        else if (!e1[0]) e.kind = 2'd1;
        else begin
            a2 = {e1[31:1], 1'b0} + {20'd0, va[21:12], 2'b00};
            fetch_q.push_back(a2); fetch_tag_q.push_back({tag, " R4"});
            e2 = rd(a2);
            perm = w ? e2[2] : e2[1];
            if (errmap.exists(a2)) e.kind = 2'd2;
            else if (!e2[0] || !perm) e.kind = 2'd1;
            else begin
                e.kind = 2'd0;
                e.paddr = {e2[31:12], va[11:0]};
            end
        end
        if (e.kind == 2'd0) begin e.faddr = '0; e.fwrite = 1'b0; end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_vaddr = va; req_is_write = w; dir_base = base; req_valid = 1'b1;
        exp_q.push_back(e);
        n_req++;
        @(negedge clk);
        req_valid = 1'b0;
        dir_base = 32'hDEAD_0000;
        check(!req_ready, {tag, " R2 busy"}, {31'd0, req_ready}, 32'd0);
    endtask

    // memory model and fetch-address monitor
    initial begin
        int lat = 0;
        int pend = 0;
        int k = 0;
        logic [31:0] pa = '0;
        forever begin
            @(negedge clk);
            k++;
            mem_rsp_valid = 1'b0;
            mem_rsp_err = 1'b0;
            if (pend != 0) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = rd(pa);
                    mem_rsp_err = errmap.exists(pa);
                    pend = 0;
                end else lat--;
            end
            mem_req_ready = (k % 5) != 2 && (k % 7) != 3;
            if (mem_req_valid && mem_req_ready && rst_n) begin
                if (fetch_q.size() == 0) begin
                    check(0, "R6 extra fetch", mem_req_addr, 32'h0);
                end else begin
                    logic [31:0] ea;
                    string t;
                    ea = fetch_q.pop_front();
                    t = fetch_tag_q.pop_front();
                    check(mem_req_addr == ea, t, mem_req_addr, ea);
                end
                pa = mem_req_addr;
                pend = 1;
                lat = k % 3;
            end
        end
    end

    // result monitor
    initial begin
        forever begin
            @(negedge clk);
            if (res_valid) begin
                exp_t e;
                n_res++;
                if (exp_q.size() == 0) begin
                    check(0, "R10 unexpected result", 32'h1, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(res_fault_kind == e.kind, {e.tag, " kind"}, {30'd0, res_fault_kind}, {30'd0, e.kind});
                    check(res_paddr == e.paddr, {e.tag, " paddr"}, res_paddr, e.paddr);
                    if (e.kind != 2'd0) begin
                        check(res_fault_addr == e.faddr, {e.tag, " R10 faddr"}, res_fault_addr, e.faddr);
                        check(res_fault_write == e.fwrite, {e.tag, " R10 fwrite"},
                              {31'd0, res_fault_write}, {31'd0, e.fwrite});
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                bad++; total++;
                $display("FAIL watchdog R10 actual=%0d expected=%0d", n_res, n_req);
                finish_run();
            end
        end
    end

    initial begin
        // page tables under base 0x0010_0000, table at 0x0020_0000
        mem[32'h0010_0004] = 32'h0020_0001;
        mem[32'h0020_0004] = 32'hABCD_E007;
        mem[32'h0020_0008] = 32'h1111_1003;
        mem[32'h0020_000C] = 32'h2222_2005;
        mem[32'h0020_0010] = 32'h3333_31FF;
        mem[32'h0020_0014] = 32'h4444_41F9;
        mem[32'h0020_0018] = 32'h5555_5006;
        mem[32'h0010_0020] = 32'h0060_0001;
        errmap[32'h0010_001C] = 1;
        errmap[32'h0060_0008] = 1;
        mem[32'h0010_0FFC] = 32'h0070_0001;
        mem[32'h0070_0FFC] = 32'h9876_5003;
        // second directory at 0x0030_0000
        mem[32'h0030_0004] = 32'h0050_0001;
        mem[32'h0050_0004] = 32'hCAFE_1007;

        #5;
        check(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
        check(res_valid == 1'b0, "R1 res_valid", {31'd0, res_valid}, 32'd0);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        translate(32'h0040_1234, 1'b0, 32'h0010_0000, "R5 rw read");
        translate(32'h0040_1FFF, 1'b1, 32'h0010_0000, "R5 rw write");
        translate(32'h0040_2010, 1'b0, 32'h0010_0000, "R8 ro read");
        translate(32'h0040_2010, 1'b1, 32'h0010_0000, "R8 ro write");
        translate(32'h0040_3020, 1'b0, 32'h0010_0000, "R8 wo read");
        translate(32'h0040_3020, 1'b1, 32'h0010_0000, "R8 wo write");
        translate(32'h0040_4ABC, 1'b1, 32'h0010_0000, "R8 attr ok");
        translate(32'h0040_5ABC, 1'b0, 32'h0010_0000, "R8 attr noperm");
        translate(32'h0040_6000, 1'b1, 32'h0010_0000, "R7 l2 absent");
        translate(32'h0040_7000, 1'b0, 32'h0010_0000, "R7 l2 empty");
        translate(32'h0140_0000, 1'b1, 32'h0010_0000, "R6 l1 absent");
        translate(32'h01C0_0123, 1'b0, 32'h0010_0000, "R9 l1 buserr");
        translate(32'h0200_2456, 1'b1, 32'h0010_0000, "R9 l2 buserr");
        translate(32'hFFFF_FFFF, 1'b0, 32'h0010_0000, "R5 top index");
        translate(32'h0040_1777, 1'b0, 32'h0030_0000, "R3 new base");
        translate(32'h0040_1777, 1'b1, 32'h0030_0000, "R3 base captured");

        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R10 pending results", exp_q.size(), 0);
        check(n_res == n_req, "R10 result count", n_res, n_req);
        check(fetch_q.size() == 0, "R6 missing fetch", fetch_q.size(), 0);
        check(req_ready == 1'b1, "R2 idle at end", {31'd0, req_ready}, 32'd1);
        finish_run();
    end
endmodule